// File: doc/BRIEF.md
# Sixteen-Bit Multicycle Processor Core

This block is a small processor core with a 16-bit datapath and eight 16-bit general registers. It talks to a single shared memory port. The port carries an address, write data, combinational read data, a direction strobe (high for a read, low for a write) and an access-valid strobe. The direction strobe only has meaning while the access-valid strobe is high. Every memory access completes in the cycle in which it is issued.

After reset a short boot sequence clears the program counter. The core then repeats two steps. In the first cycle it fetches one instruction word into its instruction register and advances the program counter. In the second cycle it executes that instruction.

Eight opcodes are defined, all with fixed operand fields. Three of them take a second word, called the immediate, which is read during the execute cycle from the word that follows the opcode word. The defined instructions are:
- no-op
- register-indirect load and store
- register copy
- load of an immediate
- jump to an immediate address
- compare-and-jump, which tests two registers against each other
- increment

Any undefined opcode acts as a no-op.

Top module: `cpu16_core`

## Requirements
- R1: While `rst_n` is low, `mem_vld` stays low. After `rst_n` rises, the core spends `BOOT_CYCLES` cycles (2 by default) in a quiet boot phase. Its first memory access is then a read (`mem_rd` high) at address 0x0000.
- R2: Each instruction starts with a read at the program counter, after which the program counter advances by one. Instruction bits 15:11 hold the opcode, bits 5:3 the source register and bits 2:0 the destination register. Every instruction takes exactly two cycles: a fetch cycle followed by an execute cycle. For a two-word instruction, the immediate read in the execute cycle is at fetch address + 1.
- R3: Opcode 00001 (load) reads memory at the address held in the source register and writes the word read into the destination register.
- R4: Opcode 00010 (store) writes the source register to memory at the address held in the destination register. The write lasts one cycle with `mem_vld` high and `mem_rd` low. No other instruction writes memory.
- R5: Opcode 00011 (copy) writes the source register's value into the destination register and leaves the source register unchanged.
- R6: Opcode 00100 (load immediate) writes the immediate word into the destination register. Execution continues at the word after the immediate.
- R7: Opcode 00101 (jump) loads the immediate word into the program counter.
- R8: Opcode 00110 (compare-and-jump) loads the immediate into the program counter when the source register is greater than the destination register, compared as unsigned numbers. Otherwise, including when the two are equal, execution continues at the word after the immediate.
- R9: Opcode 00111 (increment) adds one to the destination register, modulo 2^16, so 0xFFFF becomes 0x0000.
- R10: Opcodes 01000 through 11111 make no memory access in their execute cycle and change no register. Execution continues at the next word.
- R11: The program counter wraps modulo 2^16. A fetch at 0xFFFF of a one-word instruction is followed by a fetch at 0x0000.
- R12: A copy loop built from load immediate, load, store, increment, compare-and-jump and jump reproduces an eight-word source region exactly in a destination region, and writes nothing past that region.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Write data (source register) |
| mem_rdata | input | 16 | Read data, valid in the same cycle as the address |
| mem_rd | output | 1 | Direction: 1 = read, 0 = write; qualified by `mem_vld` |
| mem_vld | output | 1 | Memory access valid this cycle |

## Verification
Timing is checked on the memory port:
- The first read after reset must appear within a few cycles of release, and it must be at address 0.
- The cycle number of every read is logged. Consecutive fetches must be exactly two cycles apart, and an immediate read must come exactly one cycle after its fetch.

Architectural results (register values, branch outcomes, undefined opcodes) can only be seen at the memory port. Each scenario therefore ends its program with stores of the registers under test, followed by a jump-to-self. The bench runs a fixed number of cycles that is well above the length of the program, and only then compares bench memory and the logged write count with values worked out from the requirements.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;

  localparam int XLEN  = 16;
  localparam int NREG  = 8;
  localparam int OPC_W = 5;
  localparam int RSEL_W = $clog2(NREG);

  typedef enum logic [OPC_W-1:0] {
    OPC_NOP   = 5'b00000,
    OPC_LOAD  = 5'b00001,
    OPC_STORE = 5'b00010,
    OPC_COPY  = 5'b00011,
    OPC_LDIMM = 5'b00100,
    OPC_JMP   = 5'b00101,
    OPC_JGT   = 5'b00110,
    OPC_INCR  = 5'b00111
  } opcode_e;

  typedef enum logic [1:0] {
    ST_BOOT  = 2'd0,
    ST_FETCH = 2'd1,
    ST_EXEC  = 2'd2
  } ctrl_state_e;

  function automatic logic [XLEN-1:0] plus_one(input logic [XLEN-1:0] v);
    return v + XLEN'(1);
  endfunction

  function automatic logic above_unsigned(input logic [XLEN-1:0] a,
                                          input logic [XLEN-1:0] b);
    return a > b;
  endfunction

  function automatic logic opcode_known(input logic [OPC_W-1:0] op);
    return op[OPC_W-1:3] == '0;
  endfunction

endpackage

// File: rtl/cpu16_regfile.sv
module cpu16_regfile
  import cpu16_pkg::*;
#(
  parameter int N      = NREG,
  parameter int W      = XLEN,
  parameter int SEL_W  = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEL_W-1:0] wsel,
  input  logic [W-1:0]     wdata,
  input  logic [SEL_W-1:0] asel,
  output logic [W-1:0]     adata,
  input  logic [SEL_W-1:0] bsel,
  output logic [W-1:0]     bdata
);

  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we) begin
      regs[wsel] <= wdata;
    end
  end

  assign adata = regs[asel];
  assign bdata = regs[bsel];

endmodule

// File: rtl/cpu16_ctrl.sv
module cpu16_ctrl
  import cpu16_pkg::*;
#(
  parameter int BOOT_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic st_boot,
  output logic st_fetch,
  output logic st_exec
);

  localparam int CW = $clog2(BOOT_CYCLES + 1);

  ctrl_state_e     state;
  logic [CW-1:0]   boot_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_BOOT;
      boot_cnt <= '0;
    end else begin
      case (state)
        ST_BOOT: begin
          if (boot_cnt == CW'(BOOT_CYCLES - 1)) state <= ST_FETCH;
          else boot_cnt <= boot_cnt + 1'b1;
        end
        ST_FETCH: state <= ST_EXEC;
        default:  state <= ST_FETCH;
      endcase
    end
  end

  assign st_boot  = (state == ST_BOOT);
  assign st_fetch = (state == ST_FETCH);
  assign st_exec  = (state == ST_EXEC);

  // R2
  fetch_then_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_fetch |=> st_exec);

  // R2
  exec_then_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_exec |=> st_fetch);

endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
  import cpu16_pkg::*;
#(
  parameter int BOOT_CYCLES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            mem_rd,
  output logic            mem_vld
);

  logic st_boot, st_fetch, st_exec;

  cpu16_ctrl #(.BOOT_CYCLES(BOOT_CYCLES)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_boot  (st_boot),
    .st_fetch (st_fetch),
    .st_exec  (st_exec)
  );

  logic [XLEN-1:0] pc, ir;
  opcode_e         op;
  logic [RSEL_W-1:0] src_sel, dst_sel;
  logic [XLEN-1:0] src_val, dst_val;

  assign op      = opcode_e'(ir[15:11]);
  assign src_sel = ir[5:3];
  assign dst_sel = ir[2:0];

  logic unused_ir_bits;
  assign unused_ir_bits = ^ir[10:6];

  // Named execute-cycle events
  logic ex_load, ex_store, ex_copy, ex_ldimm, ex_jmp, ex_jgt, ex_incr;
  logic ex_imm, ex_unknown, gt_hit, br_take;

  assign ex_load    = st_exec && (op == OPC_LOAD);
  assign ex_store   = st_exec && (op == OPC_STORE);
  assign ex_copy    = st_exec && (op == OPC_COPY);
  assign ex_ldimm   = st_exec && (op == OPC_LDIMM);
  assign ex_jmp     = st_exec && (op == OPC_JMP);
  assign ex_jgt     = st_exec && (op == OPC_JGT);
  assign ex_incr    = st_exec && (op == OPC_INCR);
  assign ex_imm     = ex_ldimm || ex_jmp || ex_jgt;
  assign ex_unknown = st_exec && !opcode_known(ir[15:11]);
  assign gt_hit     = above_unsigned(src_val, dst_val);
  assign br_take    = ex_jmp || (ex_jgt && gt_hit);

  // Register file write path
  logic            rf_we;
  logic [XLEN-1:0] rf_wdata;

  assign rf_we = ex_load || ex_copy || ex_ldimm || ex_incr;

  always_comb begin
    rf_wdata = mem_rdata;
    if (ex_copy) rf_wdata = src_val;
    else if (ex_incr) rf_wdata = plus_one(dst_val);
  end

  cpu16_regfile #(.N(NREG), .W(XLEN)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (rf_we),
    .wsel  (dst_sel),
    .wdata (rf_wdata),
    .asel  (src_sel),
    .adata (src_val),
    .bsel  (dst_sel),
    .bdata (dst_val)
  );

  // Memory port
  always_comb begin
    mem_vld   = 1'b0;
    mem_rd    = 1'b1;
    mem_addr  = pc;
    mem_wdata = src_val;
    if (st_fetch || ex_imm) begin
      mem_vld = 1'b1;
    end else if (ex_load) begin
      mem_vld  = 1'b1;
      mem_addr = src_val;
    end else if (ex_store) begin
      mem_vld  = 1'b1;
      mem_rd   = 1'b0;
      mem_addr = dst_val;
    end
  end

  // Program counter and instruction register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc <= '0;
      ir <= '0;
    end else if (st_boot) begin
      pc <= '0;
    end else if (st_fetch) begin
      ir <= mem_rdata;
      pc <= plus_one(pc);
    end else if (br_take) begin
      pc <= mem_rdata;
    end else if (ex_imm) begin
      pc <= plus_one(pc);
    end
  end

  // R1
  boot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_boot |-> !mem_vld);

  // R2
  imm_follows_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_fetch |=> (!ex_imm || mem_addr == $past(pc) + XLEN'(1)));

  // R4
  write_only_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_vld && !mem_rd) |-> ex_store);

  // R7
  branch_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_take |=> pc == $past(mem_rdata));

  // R8
  jgt_fallthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_jgt && !gt_hit) |=> pc == $past(pc) + XLEN'(1));

  // R10
  unknown_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ex_unknown |-> (!mem_vld && !rf_we));

endmodule

// File: tb/cpu16_core_bench.sv
module cpu16_core_bench;

  localparam logic [4:0] O_NOP = 5'b00000, O_LD = 5'b00001, O_ST = 5'b00010,
                         O_CP = 5'b00011, O_LI = 5'b00100, O_JMP = 5'b00101,
                         O_JGT = 5'b00110, O_INC = 5'b00111;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_rd, mem_vld;

  always #4 clk = ~clk;

  cpu16_core u_cpu16_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_rd    (mem_rd),
    .mem_vld   (mem_vld)
  );

  logic [15:0] mem [0:255];
  assign mem_rdata = mem[mem_addr[7:0]];

  int n_tests = 0, n_fail = 0;
  int cyc = 0, wr_count = 0, wp = 0;
  int first_rd [0:15];
  logic [15:0] prev_rd;
  logic wrap_seen;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && mem_vld) begin
      if (!mem_rd) begin
        mem[mem_addr[7:0]] <= mem_wdata;
        wr_count = wr_count + 1;
      end else begin
        if (mem_addr < 16 && first_rd[mem_addr[3:0]] < 0)
          first_rd[mem_addr[3:0]] = cyc;
        if (mem_addr == 16'h0000 && prev_rd == 16'hFFFF) wrap_seen = 1'b1;
        prev_rd = mem_addr;
      end
    end
  end

  function automatic logic [15:0] enc(input logic [4:0] op, input int s, input int d);
    return {op, 5'b00000, 3'(s), 3'(d)};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic start_test();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    for (int i = 0; i < 16; i++) first_rd[i] = -1;
    wr_count = 0;
    wrap_seen = 1'b0;
    prev_rd = 16'h0000;
    wp = 0;
  endtask

  task automatic emit(input logic [15:0] w);
    mem[wp] = w;
    wp++;
  endtask

  task automatic ldi(input int d, input logic [15:0] v);
    emit(enc(O_LI, 0, d));
    emit(v);
  endtask

  task automatic halt();
    int h;
    h = wp;
    emit(enc(O_JMP, 0, 0));
    emit(16'(h));
  endtask

  task automatic go(input int n);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    int seen;
    start_test();
    halt();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R1 quiet in reset", {15'd0, mem_vld}, 16'h0000);
    end
    rst_n = 1'b1;
    seen = -1;
    for (int i = 0; i < 6; i++) begin
      if (seen < 0 && mem_vld) begin
        seen = i;
        check("R1 first access addr", mem_addr, 16'h0000);
        check("R1 first access is read", {15'd0, mem_rd}, 16'h0001);
      end
      @(negedge clk);
    end
    check("R1 first access within boot window", {15'd0, seen == 2}, 16'h0001);
  endtask

  task automatic t_timing();
    start_test();
    emit(enc(O_NOP, 0, 0));
    emit(enc(O_NOP, 0, 0));
    ldi(1, 16'h0005);
    halt();
    go(40);
    check("R2 fetch spacing one-word", 16'(first_rd[1] - first_rd[0]), 16'd2);
    check("R2 immediate one cycle after fetch", 16'(first_rd[3] - first_rd[2]), 16'd1);
    check("R2 fetch spacing two-word", 16'(first_rd[4] - first_rd[2]), 16'd2);
  endtask

  task automatic t_load_store();
    start_test();
    mem[8'h40] = 16'hBEEF;
    ldi(1, 16'h0040);
    emit(enc(O_LD, 1, 3));
    ldi(2, 16'h0050);
    emit(enc(O_ST, 3, 2));
    ldi(4, 16'hA5A5);
    ldi(5, 16'h0051);
    emit(enc(O_ST, 4, 5));
    halt();
    go(80);
    check("R3 load then R4 store", mem[8'h50], 16'hBEEF);
    check("R6 load immediate then R4 store", mem[8'h51], 16'hA5A5);
    check("R4 write count", 16'(wr_count), 16'd2);
  endtask

  task automatic t_copy_incr();
    start_test();
    ldi(1, 16'hFFFF);
    emit(enc(O_CP, 1, 2));
    emit(enc(O_INC, 0, 2));
    ldi(7, 16'h0060);
    emit(enc(O_ST, 2, 7));
    emit(enc(O_INC, 0, 7));
    emit(enc(O_ST, 1, 7));
    ldi(3, 16'h7FFF);
    emit(enc(O_INC, 0, 3));
    emit(enc(O_INC, 0, 7));
    emit(enc(O_ST, 3, 7));
    halt();
    go(100);
    check("R9 increment wraps 0xFFFF (R5 copy)", mem[8'h60], 16'h0000);
    check("R5 copy leaves source", mem[8'h61], 16'hFFFF);
    check("R9 increment 0x7FFF", mem[8'h62], 16'h8000);
  endtask

  task automatic t_jump();
    int p;
    start_test();
    mem[8'h60] = 16'hDEAD;
    ldi(7, 16'h0060);
    ldi(1, 16'h1111);
    emit(enc(O_JMP, 0, 0));
    p = wp;
    emit(16'h0000);
    emit(enc(O_ST, 1, 7));
    emit(enc(O_NOP, 0, 0));
    mem[p] = 16'(wp);
    emit(enc(O_INC, 0, 7));
    emit(enc(O_ST, 1, 7));
    halt();
    go(80);
    check("R7 skipped store", mem[8'h60], 16'hDEAD);
    check("R7 store at target", mem[8'h61], 16'h1111);
  endtask

  task automatic t_jgt(input logic [15:0] a, input logic [15:0] b, input bit taken);
    int p;
    start_test();
    ldi(1, a);
    ldi(6, b);
    ldi(7, 16'h0060);
    emit(enc(O_JGT, 1, 6));
    p = wp;
    emit(16'h0000);
    ldi(2, 16'h00F0);
    emit(enc(O_ST, 2, 7));
    halt();
    mem[p] = 16'(wp);
    ldi(2, 16'h00E1);
    emit(enc(O_ST, 2, 7));
    halt();
    go(80);
    check($sformatf("R8 compare %h > %h", a, b), mem[8'h60], taken ? 16'h00E1 : 16'h00F0);
  endtask

  task automatic t_unknown();
    start_test();
    ldi(7, 16'h0060);
    ldi(1, 16'h0123);
    emit(enc(5'b01000, 1, 7));
    emit(enc(5'b10000, 1, 7));
    emit(enc(5'b11111, 1, 7));
    emit(enc(O_ST, 1, 7));
    halt();
    go(80);
    check("R10 registers untouched", mem[8'h60], 16'h0123);
    check("R10 no extra writes", 16'(wr_count), 16'd1);
  endtask

  task automatic t_wrap();
    start_test();
    emit(enc(O_JMP, 0, 0));
    emit(16'hFFFF);
    mem[8'hFF] = enc(O_NOP, 0, 0);
    go(30);
    check("R11 fetch 0xFFFF then 0x0000", {15'd0, wrap_seen}, 16'h0001);
  endtask

  task automatic t_block_copy();
    int p, lp;
    start_test();
    for (int i = 0; i < 8; i++) mem[8'h80 + i] = 16'(16'h1357 * (i + 3));
    mem[8'hA8] = 16'h5A5A;
    ldi(1, 16'h0080);
    ldi(2, 16'h00A0);
    ldi(6, 16'h0087);
    lp = wp;
    emit(enc(O_LD, 1, 3));
    emit(enc(O_ST, 3, 2));
    emit(enc(O_INC, 0, 1));
    emit(enc(O_INC, 0, 2));
    emit(enc(O_JGT, 1, 6));
    p = wp;
    emit(16'h0000);
    emit(enc(O_JMP, 0, 0));
    emit(16'(lp));
    mem[p] = 16'(wp);
    halt();
    go(400);
    for (int i = 0; i < 8; i++)
      check($sformatf("R12 copied word %0d", i), mem[8'hA0 + i], 16'(16'h1357 * (i + 3)));
    check("R12 no write past region", mem[8'hA8], 16'h5A5A);
  endtask

  bit done = 0;

  initial begin
    t_reset();
    t_timing();
    t_load_store();
    t_copy_incr();
    t_jump();
    t_jgt(16'h0005, 16'h0003, 1'b1);
    t_jgt(16'h0003, 16'h0005, 1'b0);
    t_jgt(16'h0004, 16'h0004, 1'b0);
    t_jgt(16'h8000, 16'h0001, 1'b1);
    t_unknown();
    t_wrap();
    t_block_copy();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule